// File: doc/BRIEF.md
# Periodic Battery Test Scheduler

This block decides when a backup cell is put under a test load and keeps a sticky warning for a cell that fails. It waits for the supply supervisor's power-good signal. Power-good must then hold for a recovery delay. After that the block runs a first test at once. It then repeats the test every interval for as long as power stays good. Each test closes a load switch for a fixed window. During that window the block samples the flag from an external battery-low comparator. The measurement itself happens outside the block.

A failed test latches the warning. A passing periodic test never releases it. Only a passing test that directly follows a power-up clears the warning. Losing power stops all testing, opens the load switch and leaves the warning unchanged. The warning pin is modelled as an open-drain sink enable. All durations are counted in clock cycles and set by parameters.

Top module: `battery_test_sched`

## Requirements
- R1: While `rst_ni` is low, `load_en_o` and `warn_sink_o` are both 0.
- R2: `load_en_o` first rises `REC_TICKS` clock edges after the first edge that samples `pwr_good_i` high. That edge starts the power-up retest.
- R3: Each test window holds `load_en_o` at 1 for exactly `WINDOW_TICKS` consecutive cycles while power stays good.
- R4: After a completed window, `load_en_o` stays 0 for exactly `INTERVAL_TICKS` cycles before the next periodic window begins.
- R5: If `batt_low_i` is sampled at 1 on any edge inside a window, `warn_sink_o` becomes 1 in the same cycle that `load_en_o` falls.
- R6: A periodic test that passes leaves a set warning at 1.
- R7: At the end of a power-up retest, a pass clears the warning and a fail keeps it set.
- R8: `load_en_o` is 0 whenever `pwr_good_i` is 0. A window cut short by power loss does not change the warning.
- R9: The warning keeps its value while power is failed.
- R10: `batt_low_i` has no effect when it is sampled outside a window.
- R11: `warn_sink_o` = 1 means the open-drain driver sinks the warning line. The pin then reads low, which signals a weak cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one cycle is one tick |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Supply in tolerance, from the supervisor |
| batt_low_i | input | 1 | Comparator: cell below its trip level |
| load_en_o | output | 1 | Closes the test-load switch |
| warn_sink_o | output | 1 | Open-drain sink enable for the warning line |

## Verification
`load_en_o` follows `pwr_good_i` in the same cycle. Its rising and falling edges then come one register stage after the edge that ends a phase. The warning changes on the same edge that ends the window, so `warn_sink_o` and the falling `load_en_o` are checked in one sample. The bench changes inputs just after the falling clock edge. It samples outputs a few nanoseconds later, before the next rising edge. Directed phases count whole cycles between those samples: `REC_TICKS`+1 samples from raising power-good to the first high load, and then `WINDOW_TICKS` high samples and `INTERVAL_TICKS` low samples. A cycle-level reference model built from the requirements is compared with both outputs on every sample.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_RECOVER = 2'd1,
    ST_TEST    = 2'd2,
    ST_WAIT    = 2'd3
  } bts_state_e;
endpackage

// File: rtl/bts_phase_timer.sv
module bts_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (!last_o)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bts_seq.sv
module bts_seq
  import bts_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_good_i,
  input  logic       last_i,
  output bts_state_e state_o,
  output logic       restart_o,
  output logic       test_end_o,
  output logic       pu_test_o
);
  bts_state_e state_q, state_d;
  logic       pu_q;

  always_comb begin
    state_d = state_q;
    if (!pwr_good_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:     state_d = ST_RECOVER;
        ST_RECOVER: if (last_i) state_d = ST_TEST;
        ST_TEST:    if (last_i) state_d = ST_WAIT;
        ST_WAIT:    if (last_i) state_d = ST_TEST;
        default:    state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      pu_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      // tag the window as a power-up retest or a periodic one
      if (state_d == ST_TEST && state_q == ST_RECOVER) pu_q <= 1'b1;
      else if (state_d == ST_TEST && state_q == ST_WAIT) pu_q <= 1'b0;
    end
  end

  assign state_o    = state_q;
  assign restart_o  = (state_d != state_q) || (state_q == ST_OFF);
  assign test_end_o = (state_q == ST_TEST) && pwr_good_i && last_i;
  assign pu_test_o  = pu_q;
endmodule

// File: rtl/bts_verdict.sv
module bts_verdict (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic batt_low_i,
  input  logic test_end_i,
  input  logic pu_test_i,
  output logic warn_o
);
  logic fail_q, fail_now, warn_q;

  assign fail_now = fail_q | (sample_i & batt_low_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q <= 1'b0;
      warn_q <= 1'b0;
    end else begin
      if (test_end_i || !sample_i) fail_q <= 1'b0;
      else                         fail_q <= fail_now;
      if (test_end_i) begin
        if (fail_now)       warn_q <= 1'b1;
        else if (pu_test_i) warn_q <= 1'b0;
      end
    end
  end

  assign warn_o = warn_q;
endmodule

// File: rtl/battery_test_sched.sv
module battery_test_sched
  import bts_pkg::*;
#(
  parameter int unsigned REC_TICKS      = 200,
  parameter int unsigned WINDOW_TICKS   = 100,
  parameter int unsigned INTERVAL_TICKS = 86400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic batt_low_i,
  output logic load_en_o,
  output logic warn_sink_o
);
  localparam int unsigned MAX_A = (REC_TICKS > WINDOW_TICKS) ? REC_TICKS : WINDOW_TICKS;
  localparam int unsigned MAX_T = (MAX_A > INTERVAL_TICKS) ? MAX_A : INTERVAL_TICKS;
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] REC_LIM = CNT_W'(REC_TICKS - 1);
  localparam logic [CNT_W-1:0] WIN_LIM = CNT_W'(WINDOW_TICKS - 1);
  localparam logic [CNT_W-1:0] INT_LIM = CNT_W'(INTERVAL_TICKS - 1);

  bts_state_e       state;
  logic             restart, last, test_end, pu_test, in_test;
  logic [CNT_W-1:0] limit;

  always_comb begin
    unique case (state)
      ST_RECOVER: limit = REC_LIM;
      ST_TEST:    limit = WIN_LIM;
      ST_WAIT:    limit = INT_LIM;
      default:    limit = '0;
    endcase
  end

  bts_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .limit_i   (limit),
    .last_o    (last)
  );

  bts_seq i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_good_i (pwr_good_i),
    .last_i     (last),
    .state_o    (state),
    .restart_o  (restart),
    .test_end_o (test_end),
    .pu_test_o  (pu_test)
  );

  assign in_test = (state == ST_TEST) && pwr_good_i;

  bts_verdict i_verdict (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (in_test),
    .batt_low_i (batt_low_i),
    .test_end_i (test_end),
    .pu_test_i  (pu_test),
    .warn_o     (warn_sink_o)
  );

  assign load_en_o = in_test;
endmodule

// File: rtl/bts_checker.sv
module bts_checker #(
  parameter int unsigned REC_TICKS    = 200,
  parameter int unsigned WINDOW_TICKS = 100
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_good_i,
  input logic batt_low_i,
  input logic load_en_o,
  input logic warn_sink_o
);
  logic [31:0] win_cnt, pg_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt <= '0;
      pg_cnt  <= '0;
    end else begin
      win_cnt <= load_en_o ? win_cnt + 1 : '0;
      if (!pwr_good_i)            pg_cnt <= '0;
      else if (pg_cnt < REC_TICKS) pg_cnt <= pg_cnt + 1;
    end
  end

  assert_load_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> !load_en_o);

  assert_recovery_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_en_o) |-> pg_cnt >= REC_TICKS);

  assert_window_max_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_o |-> win_cnt < WINDOW_TICKS);

  assert_window_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(load_en_o) && pwr_good_i && $past(pwr_good_i)) |-> win_cnt == WINDOW_TICKS);

  assert_warn_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(load_en_o) && pwr_good_i && $past(pwr_good_i) && $past(batt_low_i)) |-> warn_sink_o);

  assert_warn_at_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(warn_sink_o) |-> $fell(load_en_o));
endmodule

bind battery_test_sched bts_checker #(
  .REC_TICKS    (REC_TICKS),
  .WINDOW_TICKS (WINDOW_TICKS)
) i_bts_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwr_good_i  (pwr_good_i),
  .batt_low_i  (batt_low_i),
  .load_en_o   (load_en_o),
  .warn_sink_o (warn_sink_o)
);

// File: tb/test_battery_test_sched.sv
`timescale 1ns/1ps
module test_battery_test_sched;
  localparam int REC  = 5;
  localparam int WIN  = 4;
  localparam int INTV = 20;

  logic clk_i = 1'b0;
  logic rst_ni, pwr_good_i, batt_low_i;
  logic load_en_o, warn_sink_o;
  int   checks = 0, errors = 0;
  bit   running = 1'b0, done = 1'b0;

  always #4 clk_i = ~clk_i;

  battery_test_sched #(
    .REC_TICKS(REC), .WINDOW_TICKS(WIN), .INTERVAL_TICKS(INTV)
  ) i_battery_test_sched (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_good_i(pwr_good_i),
    .batt_low_i(batt_low_i), .load_en_o(load_en_o), .warn_sink_o(warn_sink_o)
  );

  // reference model: 0 off, 1 recover, 2 test, 3 wait
  int m_ph, m_cnt;
  bit m_fail, m_pu, m_warn;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_ph = 0; m_cnt = 0; m_fail = 0; m_pu = 0; m_warn = 0;
    end else if (!pwr_good_i) begin
      m_ph = 0; m_cnt = 0; m_fail = 0;
    end else begin
      case (m_ph)
        0: begin m_ph = 1; m_cnt = 0; end
        1: if (m_cnt == REC - 1) begin m_ph = 2; m_cnt = 0; m_pu = 1; m_fail = 0; end
           else m_cnt++;
        2: begin
          if (m_cnt == WIN - 1) begin
            if (m_fail || batt_low_i) m_warn = 1;
            else if (m_pu) m_warn = 0;
            m_ph = 3; m_cnt = 0; m_fail = 0;
          end else begin
            m_fail = m_fail | batt_low_i; m_cnt++;
          end
        end
        default: if (m_cnt == INTV - 1) begin m_ph = 2; m_cnt = 0; m_pu = 0; end
                 else m_cnt++;
      endcase
    end
  end

  function automatic bit exp_load();
    return (m_ph == 2) && pwr_good_i;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    #3;
    if (running && rst_ni) begin
      chk(load_en_o === exp_load(), "R2 R3 R4 R8 load", load_en_o, exp_load());
      chk(warn_sink_o === m_warn, "R5 R6 R7 R9 R10 warn", warn_sink_o, m_warn);
    end
  end

  task automatic tick();
    @(negedge clk_i); #2;
  endtask

  task automatic wait_load(input logic lvl);
    for (int g = 0; g < 1000 && load_en_o !== lvl; g++) tick();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    rst_ni = 1'b0; pwr_good_i = 1'b0; batt_low_i = 1'b0;
    repeat (3) tick();
    chk(load_en_o === 1'b0, "R1 load in reset", load_en_o, 0);
    chk(warn_sink_o === 1'b0, "R1 R11 warn in reset", warn_sink_o, 0);
    rst_ni = 1'b1; running = 1'b1;
    tick();

    // R2 recovery delay
    pwr_good_i = 1'b1;
    n = 0;
    do begin tick(); n++; end while (!load_en_o && n < 100);
    chk(n == REC + 1, "R2 samples to first window", n, REC + 1);
    // R3 window length
    n = 0;
    while (load_en_o && n < 100) begin n++; tick(); end
    chk(n == WIN, "R3 window length", n, WIN);
    chk(warn_sink_o === 1'b0, "R7 passing power-up test", warn_sink_o, 0);
    // R4 interval
    n = 0;
    while (!load_en_o && n < 1000) begin n++; tick(); end
    chk(n == INTV, "R4 interval length", n, INTV);
    wait_load(1'b0);

    // R10 battery low outside window
    repeat (2) tick();
    batt_low_i = 1'b1; repeat (5) tick(); batt_low_i = 1'b0;
    wait_load(1'b1); wait_load(1'b0);
    chk(warn_sink_o === 1'b0, "R10 low outside window ignored", warn_sink_o, 0);

    // R5 one-cycle fail inside a periodic window
    wait_load(1'b1); tick();
    batt_low_i = 1'b1; tick(); batt_low_i = 1'b0;
    wait_load(1'b0);
    chk(warn_sink_o === 1'b1, "R5 R11 warning set", warn_sink_o, 1);

    // R6 periodic pass keeps warning
    wait_load(1'b1); wait_load(1'b0);
    chk(warn_sink_o === 1'b1, "R6 periodic pass keeps warning", warn_sink_o, 1);

    // R8 R9 power loss mid-window
    wait_load(1'b1); tick();
    pwr_good_i = 1'b0; #1;
    chk(load_en_o === 1'b0, "R8 load off with power", load_en_o, 0);
    repeat (6) tick();
    chk(warn_sink_o === 1'b1, "R9 warning held off power", warn_sink_o, 1);

    // R7 failing power-up retest keeps warning
    pwr_good_i = 1'b1; batt_low_i = 1'b1;
    wait_load(1'b1); wait_load(1'b0);
    batt_low_i = 1'b0;
    chk(warn_sink_o === 1'b1, "R7 failing retest keeps", warn_sink_o, 1);

    // R7 passing power-up retest clears
    pwr_good_i = 1'b0; repeat (3) tick();
    pwr_good_i = 1'b1;
    wait_load(1'b1); wait_load(1'b0);
    chk(warn_sink_o === 1'b0, "R7 passing retest clears", warn_sink_o, 0);

    // R8 aborted window with a low sample leaves warning clear
    wait_load(1'b1);
    batt_low_i = 1'b1; tick();
    pwr_good_i = 1'b0; batt_low_i = 1'b0; repeat (4) tick();
    chk(warn_sink_o === 1'b0, "R8 aborted window no effect", warn_sink_o, 0);
    pwr_good_i = 1'b1;

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 150 == 0) pwr_good_i = ~pwr_good_i;
      batt_low_i = ($urandom % 12 == 0);
      tick();
    end

    running = 1'b0; done = 1'b1;
    summary();
    $finish;
  end
endmodule